// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block follows the power-management state of a processor core from an always-on reference clock. It takes the core's active-low stop-clock, sleep and core-reset requests. It also takes a halt-instruction pulse, a wake interrupt, a snoop/bus-busy indication, a quick-start mode select and a flag that says whether the bus clock is running. From these it works out which of seven states the core is in: Run, Halt, Grant, QStart, Snoop, Sleep and Deep.

The outputs are a one-hot state vector, a flag that is high while the core keeps its context in its lowest states, and a flag that tells the bus side snoops can be serviced. There is also a sticky error flag. It is raised when inputs move while the core cannot tolerate it. The block only observes and classifies. Clock stopping itself happens elsewhere and reaches the block as the bus-clock flag.

Named transitions:
- Run→Halt on a halt pulse.
- Run/Halt→Grant or QStart on a stop request; Grant/QStart→Run on its release.
- Halt→Run on a wake interrupt.
- Halt/Grant/QStart→Snoop and back to the same state.
- Grant→Sleep and Sleep→Grant on the sleep request.
- Sleep/QStart→Deep when the bus clock stops.
- Deep→origin after the wake delay.
- Any state except Deep→Run on core reset.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After block reset (`rst_n` low) the state is Run and `err_flag`, `ctx_kept` and `snoop_en` are low. `state_oh` is one-hot with bit 0 Run, 1 Halt, 2 Grant, 3 QStart, 4 Snoop, 5 Sleep, 6 Deep.
- R2: In Run, a low `stop_req_n` moves to Grant when `qs_mode` is 0, or to QStart when it is 1, and the stop request wins over a simultaneous halt pulse. Otherwise a high `halt_pulse` moves to Halt.
- R3: In Halt, a stop request moves to Grant or QStart as in R2. Otherwise a high `snoop_busy` moves to Snoop. Otherwise a high `wake_irq` moves to Run.
- R4: In Grant or QStart a high `snoop_busy` enters Snoop, unless a higher-priority transition from R6 or R7 applies. Snoop is left on the first edge with `snoop_busy` low, back to exactly the state it came from (Halt, Grant or QStart).
- R5: Sleep is entered only from Grant, when `doze_req_n` is low and neither a stop release nor a snoop applies. `doze_req_n` has no effect in Run or Halt. A high `doze_req_n` in Sleep returns to Grant.
- R6: In Grant or QStart, a high `stop_req_n` returns to Run, with priority over every other input.
- R7: A low `bclk_live` moves Sleep or QStart to Deep, and the block remembers which of the two it left.
- R8: In Deep, the state returns to the remembered origin on the WAKE_CYC-th consecutive edge with `bclk_live` high. WAKE_CYC is REF_CLK_HZ*WAKE_MS/1000, which is 983 by default. A low `bclk_live` restarts the count.
- R9: A low `cpu_rst_req_n` in any state but Deep gives Run on the next edge.
- R10: If `cpu_rst_req_n` is low in Sleep, then on the following edge both `stop_req_n` and `doze_req_n` must be high, otherwise `err_flag` is set.
- R11: In Sleep, except on a core-reset edge, any change of `stop_req_n`, `halt_pulse`, `wake_irq`, `snoop_busy` or `qs_mode` sets `err_flag`. In Deep a change of those or of `doze_req_n` sets it. No snoop is serviced in Sleep.
- R12: A low `cpu_rst_req_n` in Deep sets `err_flag` and the state stays Deep.
- R13: In QStart, and in Snoop entered from QStart, a change of `qs_mode` or a high `halt_pulse` sets `err_flag`. `snoop_busy` may change freely there.
- R14: `ctx_kept` is high exactly in Sleep and Deep. `snoop_en` is high exactly in Halt, Grant, QStart and Snoop. `err_flag`, once set, stays high until `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| stop_req_n | input | 1 | Stop-clock request, active low |
| doze_req_n | input | 1 | Sleep request, active low |
| cpu_rst_req_n | input | 1 | Core reset request, active low |
| halt_pulse | input | 1 | Halt instruction executed |
| wake_irq | input | 1 | Wake interrupt for Halt |
| snoop_busy | input | 1 | Snoop pending or bus busy |
| qs_mode | input | 1 | Select QStart instead of Grant |
| bclk_live | input | 1 | Bus clock running |
| state_oh | output | 7 | One-hot state |
| ctx_kept | output | 1 | Context retained (Sleep, Deep) |
| snoop_en | output | 1 | Snoops serviceable |
| err_flag | output | 1 | Sticky illegal-input flag |

## Verification
Every output comes from a register, so an input sampled on one rising edge shows its effect right after that edge. A state change, or the error caused by a change, is visible one edge after the stimulus. The reset-in-Sleep release rule is judged on the second edge. The Deep exit is due on the WAKE_CYC-th edge after `bclk_live` rises, and the bench checks one edge before and at that edge. Inputs are driven on the falling edge, and a behavioural model updated on rising edges is compared with all outputs on every falling edge, so each result is sampled half a period after the edge that produced it.

// File: rtl/pwr_state_pkg.sv
`timescale 1ns/1ps
package pwr_state_pkg;

    localparam int NUM_ST = 7;

    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_HALT   = 3'd1,
        ST_GRANT  = 3'd2,
        ST_QSTART = 3'd3,
        ST_SNOOP  = 3'd4,
        ST_SLEEP  = 3'd5,
        ST_DEEP   = 3'd6
    } pstate_e;

    // Request bundle sampled every reference-clock edge.
    typedef struct packed {
        logic stop_n;
        logic doze_n;
        logic halt;
        logic wake;
        logic snoop;
        logic qs;
    } req_t;

    localparam req_t REQ_IDLE = '{stop_n: 1'b1, doze_n: 1'b1, halt: 1'b0,
                                  wake: 1'b0, snoop: 1'b0, qs: 1'b0};

endpackage

// File: rtl/pwr_wake_timer.sv
`timescale 1ns/1ps
module pwr_wake_timer #(
    parameter int WAKE_CYC = 983
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    output logic done
);
    localparam int CW = (WAKE_CYC < 2) ? 1 : $clog2(WAKE_CYC);
    localparam logic [CW-1:0] LAST = CW'(WAKE_CYC - 1);

    logic [CW-1:0] cnt_q;

    assign done = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || clr || done) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwr_input_guard.sv
`timescale 1ns/1ps
module pwr_input_guard
    import pwr_state_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  req_t    req,
    input  logic    cpu_rst_n,
    input  pstate_e state,
    input  logic    snoop_from_qs,
    output logic    err_set
);
    req_t prev_q;
    req_t chg;
    logic rst_sleep_q;
    logic sleep_bad, deep_bad, release_bad, qs_bad;

    assign chg = req_t'(req ^ prev_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q      <= REQ_IDLE;
            rst_sleep_q <= 1'b0;
        end else begin
            prev_q      <= req;
            rst_sleep_q <= (state == ST_SLEEP) && !cpu_rst_n;
        end
    end

    always_comb begin
        sleep_bad   = (state == ST_SLEEP) && cpu_rst_n &&
                      (chg.stop_n || chg.halt || chg.wake || chg.snoop || chg.qs);
        deep_bad    = (state == ST_DEEP) && ((|chg) || !cpu_rst_n);
        release_bad = rst_sleep_q && (!req.stop_n || !req.doze_n);
        qs_bad      = ((state == ST_QSTART) || snoop_from_qs) && (chg.qs || req.halt);
        err_set     = sleep_bad || deep_bad || release_bad || qs_bad;
    end
endmodule

// File: rtl/pwr_fsm.sv
`timescale 1ns/1ps
module pwr_fsm
    import pwr_state_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  req_t              req,
    input  logic              cpu_rst_n,
    input  logic              bclk_live,
    input  logic              wake_done,
    input  logic              err_set,
    output pstate_e           state_q,
    output logic              snoop_from_qs,
    output logic              deep_run,
    output logic              cnt_clr,
    output logic [NUM_ST-1:0] state_oh,
    output logic              ctx_kept,
    output logic              snoop_en,
    output logic              err_flag
);
    pstate_e state_d;
    pstate_e snp_org_q, snp_org_d;
    logic    deep_qs_q, deep_qs_d;
    logic    err_q;

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_RUN;
            snp_org_q <= ST_RUN;
            deep_qs_q <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            state_q   <= state_d;
            snp_org_q <= snp_org_d;
            deep_qs_q <= deep_qs_d;
            err_q     <= err_q | err_set;
        end
    end

    // Next-state logic
    always_comb begin
        state_d   = state_q;
        snp_org_d = snp_org_q;
        deep_qs_d = deep_qs_q;
        if (!cpu_rst_n && (state_q != ST_DEEP)) begin
            state_d = ST_RUN;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (!req.stop_n)   state_d = req.qs ? ST_QSTART : ST_GRANT;
                    else if (req.halt) state_d = ST_HALT;
                end
                ST_HALT: begin
                    if (!req.stop_n) begin
                        state_d = req.qs ? ST_QSTART : ST_GRANT;
                    end else if (req.snoop) begin
                        state_d   = ST_SNOOP;
                        snp_org_d = ST_HALT;
                    end else if (req.wake) begin
                        state_d = ST_RUN;
                    end
                end
                ST_GRANT: begin
                    if (req.stop_n) begin
                        state_d = ST_RUN;
                    end else if (req.snoop) begin
                        state_d   = ST_SNOOP;
                        snp_org_d = ST_GRANT;
                    end else if (!req.doze_n) begin
                        state_d = ST_SLEEP;
                    end
                end
                ST_QSTART: begin
                    if (req.stop_n) begin
                        state_d = ST_RUN;
                    end else if (!bclk_live) begin
                        state_d   = ST_DEEP;
                        deep_qs_d = 1'b1;
                    end else if (req.snoop) begin
                        state_d   = ST_SNOOP;
                        snp_org_d = ST_QSTART;
                    end
                end
                ST_SNOOP: begin
                    if (!req.snoop) state_d = snp_org_q;
                end
                ST_SLEEP: begin
                    if (!bclk_live) begin
                        state_d   = ST_DEEP;
                        deep_qs_d = 1'b0;
                    end else if (req.doze_n) begin
                        state_d = ST_GRANT;
                    end
                end
                ST_DEEP: begin
                    if (wake_done) state_d = deep_qs_q ? ST_QSTART : ST_SLEEP;
                end
                default: state_d = ST_RUN;
            endcase
        end
    end

    // Output process
    always_comb begin
        ctx_kept = 1'b0;
        snoop_en = 1'b0;
        unique case (state_q)
            ST_SLEEP, ST_DEEP:                      ctx_kept = 1'b1;
            ST_HALT, ST_GRANT, ST_QSTART, ST_SNOOP: snoop_en = 1'b1;
            default: ;
        endcase
    end

    for (genvar g = 0; g < NUM_ST; g++) begin : g_oh
        assign state_oh[g] = (state_q == pstate_e'(g));
    end

    assign snoop_from_qs = (state_q == ST_SNOOP) && (snp_org_q == ST_QSTART);
    assign deep_run      = (state_q == ST_DEEP) && bclk_live;
    assign cnt_clr       = !cpu_rst_n && (state_q != ST_DEEP);
    assign err_flag      = err_q;
endmodule

// File: rtl/pwr_state_ctrl.sv
`timescale 1ns/1ps
module pwr_state_ctrl
    import pwr_state_pkg::*;
#(
    parameter int REF_CLK_HZ = 32768,
    parameter int WAKE_MS    = 30
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        stop_req_n,
    input  logic        doze_req_n,
    input  logic        cpu_rst_req_n,
    input  logic        halt_pulse,
    input  logic        wake_irq,
    input  logic        snoop_busy,
    input  logic        qs_mode,
    input  logic        bclk_live,
    output logic [6:0]  state_oh,
    output logic        ctx_kept,
    output logic        snoop_en,
    output logic        err_flag
);
    localparam int WAKE_CYC = (REF_CLK_HZ * WAKE_MS) / 1000;

    req_t    req;
    pstate_e state;
    logic    snoop_from_qs, deep_run, cnt_clr, wake_done, err_set;

    assign req = '{stop_n: stop_req_n, doze_n: doze_req_n, halt: halt_pulse,
                   wake: wake_irq, snoop: snoop_busy, qs: qs_mode};

    pwr_wake_timer #(.WAKE_CYC(WAKE_CYC)) timer_i (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (deep_run),
        .clr  (cnt_clr),
        .done (wake_done)
    );

    pwr_input_guard guard_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req          (req),
        .cpu_rst_n    (cpu_rst_req_n),
        .state        (state),
        .snoop_from_qs(snoop_from_qs),
        .err_set      (err_set)
    );

    pwr_fsm fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req          (req),
        .cpu_rst_n    (cpu_rst_req_n),
        .bclk_live    (bclk_live),
        .wake_done    (wake_done),
        .err_set      (err_set),
        .state_q      (state),
        .snoop_from_qs(snoop_from_qs),
        .deep_run     (deep_run),
        .cnt_clr      (cnt_clr),
        .state_oh     (state_oh),
        .ctx_kept     (ctx_kept),
        .snoop_en     (snoop_en),
        .err_flag     (err_flag)
    );
endmodule

// File: rtl/pwr_state_ctrl_chk.sv
`timescale 1ns/1ps
module pwr_state_ctrl_chk #(
    parameter int REF_CLK_HZ = 32768,
    parameter int WAKE_MS    = 30
) (
    input logic       clk,
    input logic       rst_n,
    input logic       doze_req_n,
    input logic       cpu_rst_req_n,
    input logic       bclk_live,
    input logic [6:0] state_oh,
    input logic       err_flag
);
    localparam int WAKE_CYC = (REF_CLK_HZ * WAKE_MS) / 1000;
    localparam int B_GRANT = 2, B_QS = 3, B_SNP = 4, B_SLP = 5, B_DEEP = 6;

    logic [6:0] snp_org;
    int         live_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snp_org  <= 7'b0000001;
            live_cnt <= 0;
        end else begin
            if (!state_oh[B_SNP]) snp_org <= state_oh;
            if (state_oh[B_DEEP] && bclk_live) live_cnt <= live_cnt + 1;
            else                               live_cnt <= 0;
        end
    end

    p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_oh) == 1);

    p_snoop_return_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(state_oh[B_SNP]) && $past(cpu_rst_req_n)) |-> (state_oh == snp_org));

    p_sleep_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_oh[B_SLP]) |-> ($past(state_oh[B_GRANT]) && !$past(doze_req_n))
                                    || $past(state_oh[B_DEEP]));

    p_deep_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_oh[B_DEEP]) |-> (!$past(bclk_live) &&
                                     ($past(state_oh[B_SLP]) || $past(state_oh[B_QS]))));

    p_wake_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(state_oh[B_DEEP]) |-> (live_cnt == WAKE_CYC));

    p_core_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_rst_req_n && !state_oh[B_DEEP]) |=> state_oh[0]);

    p_deep_reset_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_rst_req_n && state_oh[B_DEEP]) |=> (err_flag && state_oh[B_DEEP]));

    p_err_sticky_r14: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);
endmodule

bind pwr_state_ctrl pwr_state_ctrl_chk #(.REF_CLK_HZ(REF_CLK_HZ), .WAKE_MS(WAKE_MS)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .doze_req_n   (doze_req_n),
    .cpu_rst_req_n(cpu_rst_req_n),
    .bclk_live    (bclk_live),
    .state_oh     (state_oh),
    .err_flag     (err_flag)
);

// File: tb/pwr_state_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_state_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = (32768 * 30) / 1000;
    localparam int M_RUN = 0, M_HALT = 1, M_GRANT = 2, M_QS = 3,
                   M_SNP = 4, M_SLP = 5, M_DEEP = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_n = 1'b1, doze_n = 1'b1, crst_n = 1'b1;
    logic halt = 1'b0, wake = 1'b0, snoop = 1'b0, qs = 1'b0, bclk = 1'b1;
    logic [6:0] state_oh;
    logic ctx_kept, snoop_en, err_flag;

    int checks = 0, fails = 0, cycles = 0;
    string cur_req = "R1";

    // behavioural model state
    int ms = M_RUN, sorg = M_RUN, dorg = M_SLP, mcnt = 0;
    bit merr = 0, mrs = 0;
    logic p_stop = 1, p_doze = 1, p_halt = 0, p_wake = 0, p_snoop = 0, p_qs = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_state_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .stop_req_n(stop_n), .doze_req_n(doze_n),
        .cpu_rst_req_n(crst_n), .halt_pulse(halt), .wake_irq(wake),
        .snoop_busy(snoop), .qs_mode(qs), .bclk_live(bclk),
        .state_oh(state_oh), .ctx_kept(ctx_kept), .snoop_en(snoop_en),
        .err_flag(err_flag)
    );

    always @(posedge clk) begin
        int nxt;
        bit e;
        if (!rst_n) begin
            ms = M_RUN; sorg = M_RUN; dorg = M_SLP; mcnt = 0; merr = 0; mrs = 0;
            p_stop = 1; p_doze = 1; p_halt = 0; p_wake = 0; p_snoop = 0; p_qs = 0;
        end else begin
            e = 0;
            if (mrs && (!stop_n || !doze_n)) e = 1;
            if (ms == M_SLP && crst_n && (stop_n != p_stop || halt != p_halt ||
                wake != p_wake || snoop != p_snoop || qs != p_qs)) e = 1;
            if (ms == M_DEEP && (stop_n != p_stop || doze_n != p_doze || halt != p_halt ||
                wake != p_wake || snoop != p_snoop || qs != p_qs || !crst_n)) e = 1;
            if ((ms == M_QS || (ms == M_SNP && sorg == M_QS)) && (qs != p_qs || halt)) e = 1;
            nxt = ms;
            if (ms == M_DEEP && bclk) begin
                if (mcnt == W - 1) begin nxt = dorg; mcnt = 0; end
                else mcnt = mcnt + 1;
            end else mcnt = 0;
            if (!crst_n && ms != M_DEEP) nxt = M_RUN;
            else if (ms == M_RUN) begin
                if (!stop_n) nxt = qs ? M_QS : M_GRANT; else if (halt) nxt = M_HALT;
            end else if (ms == M_HALT) begin
                if (!stop_n) nxt = qs ? M_QS : M_GRANT;
                else if (snoop) begin nxt = M_SNP; sorg = M_HALT; end
                else if (wake) nxt = M_RUN;
            end else if (ms == M_GRANT) begin
                if (stop_n) nxt = M_RUN;
                else if (snoop) begin nxt = M_SNP; sorg = M_GRANT; end
                else if (!doze_n) nxt = M_SLP;
            end else if (ms == M_QS) begin
                if (stop_n) nxt = M_RUN;
                else if (!bclk) begin nxt = M_DEEP; dorg = M_QS; end
                else if (snoop) begin nxt = M_SNP; sorg = M_QS; end
            end else if (ms == M_SNP) begin
                if (!snoop) nxt = sorg;
            end else if (ms == M_SLP) begin
                if (!bclk) begin nxt = M_DEEP; dorg = M_SLP; end
                else if (doze_n) nxt = M_GRANT;
            end
            mrs = (ms == M_SLP) && !crst_n;
            ms = nxt;
            merr = merr | e;
            p_stop = stop_n; p_doze = doze_n; p_halt = halt;
            p_wake = wake; p_snoop = snoop; p_qs = qs;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the rising edge
    always @(negedge clk) begin
        logic [6:0] exp_oh;
        cycles++;
        if (rst_n) begin
            exp_oh = 7'(1) << ms;
            chk(state_oh == exp_oh, cur_req, "state_oh", int'(state_oh), int'(exp_oh));
            chk(err_flag == merr, cur_req, "err_flag", int'(err_flag), int'(merr));
            chk(ctx_kept == (ms == M_SLP || ms == M_DEEP), "R14", "ctx_kept",
                int'(ctx_kept), int'(ms == M_SLP || ms == M_DEEP));
            chk(snoop_en == (ms >= M_HALT && ms <= M_SNP), "R14", "snoop_en",
                int'(snoop_en), int'(ms >= M_HALT && ms <= M_SNP));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle_inputs();
        stop_n = 1; doze_n = 1; crst_n = 1; halt = 0; wake = 0; snoop = 0; qs = 0; bclk = 1;
    endtask

    task automatic block_reset();
        idle_inputs();
        rst_n = 0; cyc(2); rst_n = 1; cyc(1);
    endtask

    task automatic to_sleep();
        stop_n = 0; cyc(2); doze_n = 0; cyc(2);
    endtask

    initial begin
        cyc(3); rst_n = 1; cyc(2);
        cur_req = "R1";
        chk(state_oh == 7'b0000001, "R1", "reset state", int'(state_oh), 1);
        chk(err_flag == 0, "R1", "reset err", int'(err_flag), 0);

        cur_req = "R2"; halt = 1; cyc(1); halt = 0; cyc(1);
        chk(state_oh == 7'b0000010, "R2", "halt entry", int'(state_oh), 2);
        cur_req = "R3"; wake = 1; cyc(1); wake = 0; cyc(1);
        cur_req = "R2"; stop_n = 0; halt = 1; cyc(1); halt = 0; cyc(1);
        chk(state_oh == 7'b0000100, "R2", "stop beats halt", int'(state_oh), 4);
        cur_req = "R6"; stop_n = 1; cyc(2);
        cur_req = "R2"; qs = 1; cyc(1); stop_n = 0; cyc(2);
        chk(state_oh == 7'b0001000, "R2", "quick-start entry", int'(state_oh), 8);
        cur_req = "R6"; stop_n = 1; cyc(1); qs = 0; cyc(1);

        cur_req = "R4"; halt = 1; cyc(1); halt = 0; snoop = 1; cyc(3); snoop = 0; cyc(1);
        chk(state_oh == 7'b0000010, "R4", "snoop back to halt", int'(state_oh), 2);
        wake = 1; cyc(1); wake = 0; stop_n = 0; cyc(2); snoop = 1; cyc(3); snoop = 0; cyc(1);
        chk(state_oh == 7'b0000100, "R4", "snoop back to grant", int'(state_oh), 4);
        stop_n = 1; cyc(1); qs = 1; cyc(1); stop_n = 0; cyc(2); snoop = 1; cyc(3); snoop = 0; cyc(1);
        chk(state_oh == 7'b0001000, "R4", "snoop back to qstart", int'(state_oh), 8);
        stop_n = 1; cyc(1); qs = 0; cyc(1);

        cur_req = "R5"; doze_n = 0; cyc(3);
        chk(state_oh == 7'b0000001, "R5", "doze ignored in run", int'(state_oh), 1);
        halt = 1; cyc(1); halt = 0; cyc(2);
        chk(state_oh == 7'b0000010, "R5", "doze ignored in halt", int'(state_oh), 2);
        wake = 1; cyc(1); wake = 0; doze_n = 1; cyc(1);
        to_sleep(); cyc(2);
        chk(state_oh == 7'b0100000 && ctx_kept, "R5", "sleep entry", int'(state_oh), 32);
        doze_n = 1; cyc(1);
        chk(state_oh == 7'b0000100, "R5", "sleep exit to grant", int'(state_oh), 4);
        stop_n = 1; cyc(2);

        cur_req = "R7"; to_sleep(); bclk = 0; cyc(1);
        chk(state_oh == 7'b1000000, "R7", "deep from sleep", int'(state_oh), 64);
        cyc(4);
        cur_req = "R8"; bclk = 1; cyc(100); bclk = 0; cyc(3); bclk = 1; cyc(W - 1);
        chk(state_oh == 7'b1000000, "R8", "still deep before delay", int'(state_oh), 64);
        cyc(1);
        chk(state_oh == 7'b0100000, "R8", "back to sleep", int'(state_oh), 32);
        doze_n = 1; cyc(1); stop_n = 1; cyc(2);
        cur_req = "R7"; qs = 1; cyc(1); stop_n = 0; cyc(2); bclk = 0; cyc(3);
        cur_req = "R8"; bclk = 1; cyc(W);
        chk(state_oh == 7'b0001000, "R8", "back to qstart", int'(state_oh), 8);
        stop_n = 1; cyc(1); qs = 0; cyc(1);

        cur_req = "R9"; stop_n = 0; cyc(2); crst_n = 0; cyc(1);
        chk(state_oh == 7'b0000001, "R9", "core reset to run", int'(state_oh), 1);
        crst_n = 1; stop_n = 1; cyc(2);

        cur_req = "R10"; to_sleep(); crst_n = 0; cyc(2); idle_inputs(); cyc(2);
        chk(err_flag == 1, "R10", "late release flagged", int'(err_flag), 1);
        cur_req = "R14"; block_reset();
        chk(err_flag == 0, "R14", "err cleared by rst_n", int'(err_flag), 0);
        cur_req = "R10"; to_sleep(); crst_n = 0; cyc(1); idle_inputs(); cyc(3);
        chk(err_flag == 0, "R10", "prompt release ok", int'(err_flag), 0);

        cur_req = "R11"; to_sleep(); snoop = 1; cyc(2);
        chk(state_oh == 7'b0100000, "R11", "no snoop in sleep", int'(state_oh), 32);
        chk(err_flag == 1, "R11", "change in sleep", int'(err_flag), 1);
        block_reset();

        cur_req = "R12"; qs = 1; cyc(1); stop_n = 0; cyc(2); bclk = 0; cyc(2); crst_n = 0; cyc(1);
        chk(err_flag == 1 && state_oh == 7'b1000000, "R12", "reset in deep", int'(err_flag), 1);
        block_reset();

        cur_req = "R13"; qs = 1; cyc(1); stop_n = 0; cyc(2); snoop = 1; cyc(2);
        chk(err_flag == 0, "R13", "snoop allowed from qstart", int'(err_flag), 0);
        qs = 0; cyc(1);
        chk(err_flag == 1, "R13", "qs change in snoop", int'(err_flag), 1);
        snoop = 0; cyc(2); block_reset();
        qs = 1; cyc(1); stop_n = 0; cyc(2); halt = 1; cyc(1); halt = 0;
        chk(err_flag == 1, "R13", "halt in qstart", int'(err_flag), 1);
        block_reset();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule